// File: doc/BRIEF.md
# Handle-Based Shared Memory Translator

This block is the handle table that sits in front of a shared SRAM pool used by several accelerators. A host adds and removes handles through a small memory-mapped write port. Each handle maps a power-of-two region of the pool and makes it behave as a random-access memory, a FIFO, or a hybrid of the two. Accelerators send requests that name a handle ID, an opcode and, for reads and writes, an offset. The block turns each request into a physical SRAM address and keeps the FIFO head, tail and full state. It returns a response one cycle later, with either data, a completion, or an error code.

Each FIFO or hybrid handle can carry an occupancy trigger. When the element count lands on that value, the host receives a one-cycle interrupt that names the handle. The SRAM is modelled inside the block as a synchronous single-port array. Arbitration between requesters happens upstream, so the block accepts at most one request per cycle.

Top module: `shmem_xlate`

## Requirements
- R1: After reset, no response and no interrupt is raised, and every handle is unallocated.
- R2: A management write to address {hid, sel} updates one field of a handle. The sel values are:
  - sel=0 is control: bit0 = allocated, bits 2:1 = type (0 random, 1 FIFO, 2 hybrid, 3 reserved). Writing it with bit0=1 empties the handle, and writing it with bit0=0 removes the handle.
  - sel=1 is the start address.
  - sel=2 is the size mask (size minus one).
  - sel=3 is the trigger.
- R3: Each request is answered in the following cycle. A random-access read or write uses physical address (start + offset) mod 2^ADDR_W. A read returns the stored word with rsp_has_data_o=1. A write returns a completion with rsp_has_data_o=0.
- R4: A read or write whose offset has a bit set outside the size mask returns code 2, and memory is left unchanged.
- R5: Any request to an unallocated handle returns code 1.
- R6: Opcodes are read=0, write=1, get=2 and put=3. A get or put on a random handle, a read or write on a FIFO handle, and any request to a reserved-type handle all return code 5.
- R7: A FIFO or hybrid get reads at start+head. A put writes at start+tail. Both pointers advance modulo the region size, so data leaves in arrival order across any number of wraps.
- R8: A get when the handle holds no element returns code 3 and changes no pointer.
- R9: A put when the handle holds size elements returns code 4, writes no memory and leaves the tail unchanged.
- R10: A hybrid read or write at offset k accesses element (head + k) mod size and never changes head, tail or occupancy.
- R11: When a get or put leaves a handle's element count equal to its nonzero trigger, irq_o pulses for one cycle with irq_hid_o naming the handle, aligned with that response. A trigger of zero never raises it.
- R12: A successful response carries code 0. An error response never carries data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mgmt_we_i | input | 1 | Management write strobe |
| mgmt_addr_i | input | HID_W+2 | {handle ID, field select} |
| mgmt_wdata_i | input | ADDR_W | Management write data |
| req_valid_i | input | 1 | Request valid |
| req_op_i | input | 2 | Opcode: read 0, write 1, get 2, put 3 |
| req_hid_i | input | HID_W | Handle ID |
| req_offset_i | input | ADDR_W | Offset for read and write |
| req_wdata_i | input | DATA_W | Data for write and put |
| rsp_valid_o | output | 1 | Response valid |
| rsp_code_o | output | 3 | Response code, 0 = success |
| rsp_has_data_o | output | 1 | Response carries read data |
| rsp_data_o | output | DATA_W | Read data |
| irq_o | output | 1 | Occupancy trigger pulse |
| irq_hid_o | output | HID_W | Handle that fired the trigger |

## Verification
The assertions check the following on every cycle:
- every request gets its response one cycle later;
- an error response never carries data;
- the interrupt only coincides with a response;
- a set full flag always sits on equal head and tail pointers;
- pointers only move on allocated handles.

Address translation, FIFO ordering across wraps, and hybrid indexing from a moving head can only be shown by the bench's scenarios. The same holds for overlapping handles that alias the same words, for rejected puts and gets that leave memory intact, and for the trigger firing on both rising and falling counts.

// File: rtl/shx_pkg.sv
package shx_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_GET   = 2'd2,
    OP_PUT   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RT_RAND = 2'd0,
    RT_FIFO = 2'd1,
    RT_HYB  = 2'd2,
    RT_RSVD = 2'd3
  } rtype_e;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_UNALLOC = 3'd1,
    RC_RANGE   = 3'd2,
    RC_EMPTY   = 3'd3,
    RC_FULL    = 3'd4,
    RC_BADOP   = 3'd5
  } rcode_e;
endpackage

// File: rtl/shx_handle_table.sv
module shx_handle_table #(
  parameter int NUM_HANDLES = 16,
  parameter int HID_W       = 4,
  parameter int AW          = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mgmt_we_i,
  input  logic [HID_W-1:0] mgmt_hid_i,
  input  logic [1:0]       mgmt_sel_i,
  input  logic [AW-1:0]    mgmt_wdata_i,
  input  logic [HID_W-1:0] lk_hid_i,
  output logic             lk_alloc_o,
  output logic [1:0]       lk_type_o,
  output logic [AW-1:0]    lk_start_o,
  output logic [AW-1:0]    lk_mask_o,
  output logic [AW-1:0]    lk_trig_o,
  output logic [AW-1:0]    lk_head_o,
  output logic [AW-1:0]    lk_tail_o,
  output logic             lk_full_o,
  input  logic             upd_en_i,
  input  logic [AW-1:0]    upd_head_i,
  input  logic [AW-1:0]    upd_tail_i,
  input  logic             upd_full_i
);
  logic [NUM_HANDLES-1:0] alloc_q, full_q;
  logic [1:0]             type_q  [NUM_HANDLES];
  logic [AW-1:0]          start_q [NUM_HANDLES];
  logic [AW-1:0]          mask_q  [NUM_HANDLES];
  logic [AW-1:0]          trig_q  [NUM_HANDLES];
  logic [AW-1:0]          head_q  [NUM_HANDLES];
  logic [AW-1:0]          tail_q  [NUM_HANDLES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_q <= '0;
      full_q  <= '0;
      for (int i = 0; i < NUM_HANDLES; i++) begin
        type_q[i]  <= '0;
        start_q[i] <= '0;
        mask_q[i]  <= '0;
        trig_q[i]  <= '0;
        head_q[i]  <= '0;
        tail_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_HANDLES; i++) begin
        // host access has priority over a same-cycle pointer update
        if (mgmt_we_i && mgmt_hid_i == HID_W'(i)) begin
          unique case (mgmt_sel_i)
            2'd0: begin
              alloc_q[i] <= mgmt_wdata_i[0];
              type_q[i]  <= mgmt_wdata_i[2:1];
              head_q[i]  <= '0;
              tail_q[i]  <= '0;
              full_q[i]  <= 1'b0;
            end
            2'd1: start_q[i] <= mgmt_wdata_i;
            2'd2: mask_q[i]  <= mgmt_wdata_i;
            default: trig_q[i] <= mgmt_wdata_i;
          endcase
        end else if (upd_en_i && lk_hid_i == HID_W'(i)) begin
          head_q[i] <= upd_head_i;
          tail_q[i] <= upd_tail_i;
          full_q[i] <= upd_full_i;
        end
      end
    end
  end

  assign lk_alloc_o = alloc_q[lk_hid_i];
  assign lk_type_o  = type_q[lk_hid_i];
  assign lk_start_o = start_q[lk_hid_i];
  assign lk_mask_o  = mask_q[lk_hid_i];
  assign lk_trig_o  = trig_q[lk_hid_i];
  assign lk_head_o  = head_q[lk_hid_i];
  assign lk_tail_o  = tail_q[lk_hid_i];
  assign lk_full_o  = full_q[lk_hid_i];

  // pointers only move on allocated handles (R5)
  assert_upd_needs_alloc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |-> alloc_q[lk_hid_i]);

  for (genvar g = 0; g < NUM_HANDLES; g++) begin : g_chk
    assert_full_ptr_eq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_q[g] |-> head_q[g] == tail_q[g]);
  end
endmodule

// File: rtl/shx_xlate.sv
module shx_xlate
  import shx_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          alloc_i,
  input  logic [1:0]    type_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] trig_i,
  input  logic [AW-1:0] head_i,
  input  logic [AW-1:0] tail_i,
  input  logic          full_i,
  input  op_e           op_i,
  input  logic [AW-1:0] offset_i,
  output rcode_e        code_o,
  output logic [AW-1:0] addr_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic          upd_o,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] tail_o,
  output logic          full_o,
  output logic          trig_hit_o
);
  localparam logic [AW-1:0] ONE   = AW'(1);
  localparam logic [AW:0]   ONE_W = (AW+1)'(1);

  logic          is_ra, is_fifo, is_hyb, in_range, empty;
  logic [AW-1:0] rel_off, nxt_head, nxt_tail;
  logic [AW:0]   cnt_new;

  assign is_ra    = type_i == RT_RAND;
  assign is_fifo  = type_i == RT_FIFO;
  assign is_hyb   = type_i == RT_HYB;
  assign in_range = ~|(offset_i & ~mask_i);
  assign empty    = !full_i && head_i == tail_i;
  assign rel_off  = is_hyb ? ((head_i + offset_i) & mask_i) : offset_i;
  assign nxt_head = (head_i + ONE) & mask_i;
  assign nxt_tail = (tail_i + ONE) & mask_i;

  always_comb begin
    code_o   = RC_OK;
    addr_o   = start_i;
    mem_we_o = 1'b0;
    mem_re_o = 1'b0;
    upd_o    = 1'b0;
    head_o   = head_i;
    tail_o   = tail_i;
    full_o   = full_i;
    if (!alloc_i) begin
      code_o = RC_UNALLOC;
    end else begin
      unique case (op_i)
        OP_READ, OP_WRITE: begin
          if (!(is_ra || is_hyb))  code_o = RC_BADOP;
          else if (!in_range)      code_o = RC_RANGE;
          else begin
            addr_o   = start_i + rel_off;
            mem_we_o = op_i == OP_WRITE;
            mem_re_o = op_i == OP_READ;
          end
        end
        OP_GET: begin
          if (!(is_fifo || is_hyb)) code_o = RC_BADOP;
          else if (empty)           code_o = RC_EMPTY;
          else begin
            addr_o   = start_i + head_i;
            mem_re_o = 1'b1;
            upd_o    = 1'b1;
            head_o   = nxt_head;
            full_o   = 1'b0;
          end
        end
        default: begin
          if (!(is_fifo || is_hyb)) code_o = RC_BADOP;
          else if (full_i)          code_o = RC_FULL;
          else begin
            addr_o   = start_i + tail_i;
            mem_we_o = 1'b1;
            upd_o    = 1'b1;
            tail_o   = nxt_tail;
            full_o   = nxt_tail == head_i;
          end
        end
      endcase
    end
  end

  assign cnt_new    = full_o ? ({1'b0, mask_i} + ONE_W) : {1'b0, (tail_o - head_o) & mask_i};
  assign trig_hit_o = upd_o && |trig_i && cnt_new == {1'b0, trig_i};
endmodule

// File: rtl/shx_sram.sv
module shx_sram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/shmem_xlate.sv
module shmem_xlate
  import shx_pkg::*;
#(
  parameter int NUM_HANDLES = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 10,
  localparam int HID_W      = $clog2(NUM_HANDLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_we_i,
  input  logic [HID_W+1:0]  mgmt_addr_i,
  input  logic [ADDR_W-1:0] mgmt_wdata_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [HID_W-1:0]  req_hid_i,
  input  logic [ADDR_W-1:0] req_offset_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_code_o,
  output logic              rsp_has_data_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              irq_o,
  output logic [HID_W-1:0]  irq_hid_o
);
  logic              lk_alloc, lk_full, xl_we, xl_re, xl_upd, xl_full, xl_hit;
  logic [1:0]        lk_type;
  logic [ADDR_W-1:0] lk_start, lk_mask, lk_trig, lk_head, lk_tail;
  logic [ADDR_W-1:0] xl_addr, xl_head, xl_tail;
  rcode_e            xl_code, code_q;
  op_e               op;
  logic              valid_q, has_q, irq_q;
  logic [HID_W-1:0]  irq_hid_q;

  assign op = op_e'(req_op_i);

  shx_handle_table #(.NUM_HANDLES(NUM_HANDLES), .HID_W(HID_W), .AW(ADDR_W)) u_table (
    .clk_i, .rst_ni,
    .mgmt_we_i,
    .mgmt_hid_i   (mgmt_addr_i[HID_W+1:2]),
    .mgmt_sel_i   (mgmt_addr_i[1:0]),
    .mgmt_wdata_i,
    .lk_hid_i     (req_hid_i),
    .lk_alloc_o   (lk_alloc),
    .lk_type_o    (lk_type),
    .lk_start_o   (lk_start),
    .lk_mask_o    (lk_mask),
    .lk_trig_o    (lk_trig),
    .lk_head_o    (lk_head),
    .lk_tail_o    (lk_tail),
    .lk_full_o    (lk_full),
    .upd_en_i     (req_valid_i && xl_upd),
    .upd_head_i   (xl_head),
    .upd_tail_i   (xl_tail),
    .upd_full_i   (xl_full)
  );

  shx_xlate #(.AW(ADDR_W)) u_xlate (
    .alloc_i   (lk_alloc),
    .type_i    (lk_type),
    .start_i   (lk_start),
    .mask_i    (lk_mask),
    .trig_i    (lk_trig),
    .head_i    (lk_head),
    .tail_i    (lk_tail),
    .full_i    (lk_full),
    .op_i      (op),
    .offset_i  (req_offset_i),
    .code_o    (xl_code),
    .addr_o    (xl_addr),
    .mem_we_o  (xl_we),
    .mem_re_o  (xl_re),
    .upd_o     (xl_upd),
    .head_o    (xl_head),
    .tail_o    (xl_tail),
    .full_o    (xl_full),
    .trig_hit_o(xl_hit)
  );

  shx_sram #(.AW(ADDR_W), .DW(DATA_W)) u_sram (
    .clk_i,
    .we_i    (req_valid_i && xl_we),
    .re_i    (req_valid_i && xl_re),
    .addr_i  (xl_addr),
    .wdata_i (req_wdata_i),
    .rdata_o (rsp_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      code_q    <= RC_OK;
      has_q     <= 1'b0;
      irq_q     <= 1'b0;
      irq_hid_q <= '0;
    end else begin
      valid_q   <= req_valid_i;
      code_q    <= xl_code;
      has_q     <= req_valid_i && xl_code == RC_OK && (op == OP_READ || op == OP_GET);
      irq_q     <= req_valid_i && xl_hit;
      irq_hid_q <= req_hid_i;
    end
  end

  assign rsp_valid_o    = valid_q;
  assign rsp_code_o     = code_q;
  assign rsp_has_data_o = has_q;
  assign irq_o          = irq_q;
  assign irq_hid_o      = irq_hid_q;

  assert_rsp_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_spurious_rsp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_err_no_data_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o != 3'd0) |-> !rsp_has_data_o);
  assert_irq_with_rsp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rsp_valid_o && rsp_code_o == 3'd0);
endmodule

// File: tb/shmem_xlate_tb.sv
`timescale 1ns/1ps
module shmem_xlate_tb;
  localparam int NH = 16, DW = 32, AW = 10, HW = 4, DEPTH = 1 << AW;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          mgmt_we = 1'b0;
  logic [HW+1:0] mgmt_addr = '0;
  logic [AW-1:0] mgmt_wdata = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [HW-1:0] req_hid = '0;
  logic [AW-1:0] req_offset = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid, rsp_has, irq;
  logic [2:0]    rsp_code;
  logic [DW-1:0] rsp_data;
  logic [HW-1:0] irq_hid;

  always #2 clk = ~clk;

  shmem_xlate #(.NUM_HANDLES(NH), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni,
    .mgmt_we_i(mgmt_we), .mgmt_addr_i(mgmt_addr), .mgmt_wdata_i(mgmt_wdata),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_hid_i(req_hid),
    .req_offset_i(req_offset), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .rsp_has_data_o(rsp_has),
    .rsp_data_o(rsp_data), .irq_o(irq), .irq_hid_o(irq_hid)
  );

  int    vectors = 0, miscompares = 0;
  bit    done = 0;
  string tag = "R1";

  // reference model state
  bit            m_alloc [NH];
  int            m_type [NH], m_start [NH], m_mask [NH], m_trig [NH];
  int            m_head [NH], m_tail [NH], m_cnt [NH];
  logic [DW-1:0] m_mem [DEPTH];
  bit            e_valid, e_has, e_irq;
  int            e_code, e_hid;
  logic [DW-1:0] e_data;

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check("rsp_valid", 64'(rsp_valid), 64'(e_valid));
    if (e_valid) begin
      check("rsp_code", 64'(rsp_code), 64'(e_code));
      check("rsp_has_data", 64'(rsp_has), 64'(e_has));
      if (e_has) check("rsp_data", 64'(rsp_data), 64'(e_data));
    end
    check("irq", 64'(irq), 64'(e_irq));
    if (e_irq) check("irq_hid", 64'(irq_hid), 64'(e_hid));
  endtask

  task automatic model_req(int op, int h, int off, logic [DW-1:0] wd);
    int  sz, a;
    bit  moved;
    e_valid = 1; e_has = 0; e_irq = 0; e_hid = h; e_code = 0; moved = 0;
    sz = m_mask[h] + 1;
    if (!m_alloc[h]) e_code = 1;
    else if (op < 2) begin
      if (m_type[h] != 0 && m_type[h] != 2) e_code = 5;
      else if (off > m_mask[h]) e_code = 2;
      else begin
        a = (m_start[h] + (m_type[h] == 2 ? (m_head[h] + off) % sz : off)) % DEPTH;
        if (op == 1) m_mem[a] = wd;
        else begin e_has = 1; e_data = m_mem[a]; end
      end
    end else if (m_type[h] == 1 || m_type[h] == 2) begin
      if (op == 2) begin
        if (m_cnt[h] == 0) e_code = 3;
        else begin
          a = (m_start[h] + m_head[h]) % DEPTH;
          e_has = 1; e_data = m_mem[a];
          m_head[h] = (m_head[h] + 1) % sz; m_cnt[h]--; moved = 1;
        end
      end else begin
        if (m_cnt[h] == sz) e_code = 4;
        else begin
          a = (m_start[h] + m_tail[h]) % DEPTH;
          m_mem[a] = wd;
          m_tail[h] = (m_tail[h] + 1) % sz; m_cnt[h]++; moved = 1;
        end
      end
      if (moved && m_trig[h] != 0 && m_cnt[h] == m_trig[h]) e_irq = 1;
    end else e_code = 5;
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(bit v, int op, int h, int off, logic [DW-1:0] wd);
    req_valid = v; req_op = 2'(op); req_hid = HW'(h);
    req_offset = AW'(off); req_wdata = wd;
    if (v) model_req(op, h, off, wd);
    else begin e_valid = 0; e_irq = 0; end
    @(posedge clk); @(negedge clk);
    compare();
    req_valid = 0;
  endtask

  task automatic mgmt(int h, int sel, int d);
    mgmt_we = 1; mgmt_addr = {HW'(h), 2'(sel)}; mgmt_wdata = AW'(d);
    case (sel)
      0: begin
        m_alloc[h] = d[0]; m_type[h] = (d >> 1) & 3;
        m_head[h] = 0; m_tail[h] = 0; m_cnt[h] = 0;
      end
      1: m_start[h] = d;
      2: m_mask[h] = d;
      default: m_trig[h] = d;
    endcase
    step(0, 0, 0, 0, '0);
    mgmt_we = 0;
  endtask

  task automatic add(int h, int typ, int start, int mask, int trig);
    mgmt(h, 1, start);
    mgmt(h, 2, mask);
    mgmt(h, 3, trig);
    mgmt(h, 0, (typ << 1) | 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NH; i++) begin
      m_alloc[i] = 0; m_type[i] = 0; m_start[i] = 0; m_mask[i] = 0;
      m_trig[i] = 0; m_head[i] = 0; m_tail[i] = 0; m_cnt[i] = 0;
    end
    e_valid = 0; e_irq = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("rsp_valid in reset", 64'(rsp_valid), 64'd0);
    check("irq in reset", 64'(irq), 64'd0);
    rst_ni = 1;
    @(negedge clk);
    step(0, 0, 0, 0, '0);
    for (int h = 0; h < NH; h += 5) step(1, 0, h, 0, '0);

    // R5, R12: unallocated handles reject everything without data
    tag = "R5";
    step(1, 3, 2, 0, 32'h1111);
    step(1, 2, 9, 0, '0);
    tag = "R12";
    step(1, 0, 15, 3, '0);

    // R2, R3: random handles, translation and aliasing
    tag = "R2";
    add(0, 0, 'h100, 63, 0);
    add(1, 0, 'h120, 15, 0);
    tag = "R3";
    step(1, 1, 0, 'h20, 32'hA5A5_0001);
    step(1, 0, 1, 0, '0);
    for (int k = 0; k < 8; k++) step(1, 1, 1, k + 4, 32'hB000_0000 + k);
    for (int k = 0; k < 8; k++) step(1, 0, 0, 'h24 + k, '0);
    step(1, 1, 0, 'h30, 32'hC0DE_0030);
    add(2, 0, 'h3F8, 15, 0);
    add(3, 0, 'h000, 15, 0);
    step(1, 1, 2, 10, 32'hDEAD_0002);
    step(1, 0, 3, 2, '0);

    // R4: out-of-range offsets leave memory unchanged
    tag = "R4";
    step(1, 0, 1, 16, '0);
    step(1, 1, 1, 16, 32'hFFFF_FFFF);
    step(1, 1, 0, 64, 32'hEEEE_EEEE);
    step(1, 0, 0, 'h30, '0);

    // R6: unsupported op per type
    tag = "R6";
    step(1, 2, 0, 0, '0);
    step(1, 3, 1, 0, 32'h5);
    add(4, 1, 'h200, 3, 0);
    step(1, 0, 4, 0, '0);
    step(1, 1, 4, 0, 32'h7);
    add(8, 3, 'h380, 7, 0);
    step(1, 0, 8, 0, '0);
    step(1, 3, 8, 0, 32'h8);

    // R7, R8, R9: FIFO fill, overflow, drain, underflow, wraps
    tag = "R9";
    for (int k = 0; k < 4; k++) step(1, 3, 4, 0, 32'hF1F0_0000 + k);
    step(1, 3, 4, 0, 32'hBAD0_BAD0);
    tag = "R7";
    for (int k = 0; k < 4; k++) step(1, 2, 4, 0, '0);
    tag = "R8";
    step(1, 2, 4, 0, '0);
    step(1, 2, 4, 0, '0);
    tag = "R7";
    for (int k = 0; k < 10; k++) begin
      step(1, 3, 4, 0, 32'h7700_0000 + 2 * k);
      step(1, 3, 4, 0, 32'h7700_0001 + 2 * k);
      step(1, 2, 4, 0, '0);
      step(1, 2, 4, 0, '0);
    end
    step(1, 2, 4, 0, '0);

    // R2: removal and re-add empties the handle
    tag = "R2";
    step(1, 3, 4, 0, 32'h4444);
    mgmt(4, 0, 2);
    step(1, 2, 4, 0, '0);
    mgmt(4, 0, 3);
    step(1, 2, 4, 0, '0);

    // R10: hybrid indexing from head
    tag = "R10";
    add(5, 2, 'h300, 7, 0);
    for (int k = 0; k < 5; k++) step(1, 3, 5, 0, 32'h4B00_0000 + k);
    step(1, 2, 5, 0, '0);
    step(1, 2, 5, 0, '0);
    for (int k = 0; k < 3; k++) step(1, 0, 5, k, '0);
    step(1, 1, 5, 1, 32'h4B0F_FFFF);
    step(1, 0, 5, 8, '0);
    for (int k = 0; k < 4; k++) step(1, 2, 5, 0, '0);
    for (int k = 0; k < 9; k++) step(1, 3, 5, 0, 32'h4C00_0000 + k);
    for (int k = 0; k < 8; k++) step(1, 0, 5, k, '0);

    // R11: occupancy trigger, rising and falling
    tag = "R11";
    add(6, 1, 'h240, 7, 3);
    for (int k = 0; k < 4; k++) step(1, 3, 6, 0, 32'h1600_0000 + k);
    step(1, 2, 6, 0, '0);
    step(1, 2, 6, 0, '0);
    add(7, 1, 'h260, 7, 0);
    for (int k = 0; k < 8; k++) step(1, 3, 7, 0, 32'h1700_0000 + k);
    step(1, 3, 7, 0, 32'h0);
    step(0, 0, 0, 0, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule